// File: doc/BRIEF.md
# Stack Call and Interrupt Sequencer

This block carries out the stack traffic of a small 8-bit processor core. Given a start pulse and an operation code, it runs the memory cycles needed for a subroutine call or return, a software interrupt entry or return from interrupt, a single-byte push or pull, and the two moves between the stack pointer and an index register. It owns the 8-bit stack pointer and drives a byte-wide memory port. The memory has an address, write data, a write enable and read data that is valid in the same cycle as the address.

The core hands in the current program counter, status byte, register value and call target when it starts an operation. The sequencer latches them and performs one memory access per clock. It then returns the new program counter, the resulting status byte and any pulled data. These results stay on the outputs until a later operation replaces them. Busy is high while an operation runs, and a one-cycle done pulse marks its end. Status bits used: N is bit 7, V bit 6, interrupt-disable bit 2, Z bit 1, C bit 0.

Top module: `stack_seq`

## Requirements
- R1: A push (op 0) writes reg_in at address 0x0100 + SP and then decrements SP. The pointer wraps from 0x00 to 0xFF, and every stack write lands in page 0x01.
- R2: A register pull (op 1) first increments SP (wrapping 0xFF to 0x00) and then reads at 0x0100 + new SP into data_out. status_out equals status_in with bit 7 set to data bit 7 and bit 1 set when the data is zero. All other bits are unchanged.
- R3: A status pull (op 2) pre-increments SP like R2 and copies the read byte unchanged into status_out.
- R4: A call (op 3) pushes pc_in high byte and then low byte, leaving SP two lower. It then sets pc_out to target_in.
- R5: A return (op 4) pulls the low byte and then the high byte, leaving SP two higher. It sets pc_out to the pulled address plus one.
- R6: A software interrupt (op 5) pushes pc_in + 2 high byte, then its low byte, then status_in. It reads the low byte from 0xFFFE and the high byte from 0xFFFF into pc_out. status_out is status_in with bit 2 set.
- R7: A return from interrupt (op 6) pulls the status byte, then the low and the high PC bytes. status_out gets the pulled status and pc_out the pulled address with no increment.
- R8: A move into the pointer (op 7) sets SP to reg_in without any memory write. status_out equals status_in unchanged.
- R9: A move from the pointer (op 8) sets data_out to SP. status_out equals status_in with bit 7 and bit 1 updated from SP as in R2.
- R10: busy rises in the cycle after an accepted start. done is high for exactly one cycle when busy falls. The busy cycles are 1 for ops 0, 1, 2, 7 and 8, 2 for ops 3 and 4, 3 for op 6 and 5 for op 5. A start while busy is ignored.
- R11: After reset, SP is 0xFF, busy and done are low, and pc_out, status_out and data_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation on op when idle |
| op | input | 4 | Operation code (0..8, see requirements) |
| reg_in | input | 8 | Byte to push, or new SP value |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| target_in | input | 16 | Call destination address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| sp_out | output | 8 | Current stack pointer |
| pc_out | output | 16 | Resulting program counter |
| status_out | output | 8 | Resulting status byte |
| data_out | output | 8 | Pulled byte or copied SP |

## Verification
The hardest case to reach from the ports is a start that arrives during a long operation and must leave no trace. The bench raises start with a push request in the second cycle of a software interrupt entry. It then checks that the stack cell below the three pushed bytes still holds a sentinel, and that SP stops exactly three below where it began. The wrap of the pointer at both ends is reached by loading SP with zero through the pointer move and then pushing and pulling across the boundary.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [3:0] {
        OP_PUSH    = 4'd0,
        OP_PULL    = 4'd1,
        OP_PULL_ST = 4'd2,
        OP_CALL    = 4'd3,
        OP_RET     = 4'd4,
        OP_SWI     = 4'd5,
        OP_RTI     = 4'd6,
        OP_TO_SP   = 4'd7,
        OP_FROM_SP = 4'd8
    } seq_op_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PUSH,
        ACC_PULL,
        ACC_VEC_LO,
        ACC_VEC_HI
    } acc_e;

endpackage

// File: rtl/stk_port.sv
module stk_port
    import stack_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter logic [AW-1:0] PAGE = 'h0100,
    parameter logic [AW-1:0] VEC  = 'hFFFE
) (
    input  acc_e          kind,
    input  logic [SW-1:0] sp,
    output logic [AW-1:0] addr,
    output logic          we,
    output logic [SW-1:0] sp_nxt
);
    always_comb begin
        addr   = PAGE + AW'(sp);
        we     = 1'b0;
        sp_nxt = sp;
        case (kind)
            ACC_PUSH: begin
                we     = 1'b1;
                sp_nxt = sp - 1'b1;
            end
            ACC_PULL: begin
                sp_nxt = sp + 1'b1;
                addr   = PAGE + AW'(sp_nxt);
            end
            ACC_VEC_LO: addr = VEC;
            ACC_VEC_HI: addr = VEC + AW'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_nz.sv
module stk_nz #(
    parameter int DW   = 8,
    parameter int NBIT = 7,
    parameter int ZBIT = 1
) (
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] base,
    output logic [DW-1:0] flags
);
    always_comb begin
        flags       = base;
        flags[NBIT] = val[DW-1];
        flags[ZBIT] = (val == '0);
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SW   = 8,
    parameter int AW   = 16,
    parameter logic [AW-1:0] PAGE = 'h0100,
    parameter logic [AW-1:0] VEC  = 'hFFFE,
    parameter logic [SW-1:0] SP_INIT = '1,
    parameter int IBIT = 2,
    parameter int NBIT = 7,
    parameter int ZBIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [7:0]    reg_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    status_in,
    input  logic [15:0]   target_in,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    sp_out,
    output logic [15:0]   pc_out,
    output logic [7:0]    status_out,
    output logic [7:0]    data_out
);
    localparam int PCW = 2 * DW;
    localparam int STW = 3;

    typedef struct packed {
        logic           busy;
        logic           done;
        seq_op_e        op;
        logic [STW-1:0] step;
        logic [SW-1:0]  sp;
        logic [PCW-1:0] pc_w;
        logic [DW-1:0]  st_w;
        logic [DW-1:0]  reg_w;
        logic [PCW-1:0] tgt_w;
        logic [DW-1:0]  tmp;
        logic [PCW-1:0] pc_r;
        logic [DW-1:0]  st_r;
        logic [DW-1:0]  data_r;
    } seq_t;

    seq_t           s_d, s_q;
    acc_e           acc;
    logic [DW-1:0]  wdata;
    logic           last;
    logic [SW-1:0]  sp_nxt;
    logic [DW-1:0]  nz_val;
    logic [DW-1:0]  nz_out;
    logic [PCW-1:0] ret_pc;

    stk_port #(.AW(AW), .SW(SW), .PAGE(PAGE), .VEC(VEC)) u_port (
        .kind  (acc),
        .sp    (s_q.sp),
        .addr  (mem_addr),
        .we    (mem_we),
        .sp_nxt(sp_nxt)
    );

    assign nz_val = (s_q.op == OP_FROM_SP) ? DW'(s_q.sp) : mem_rdata;

    stk_nz #(.DW(DW), .NBIT(NBIT), .ZBIT(ZBIT)) u_nz (
        .val  (nz_val),
        .base (s_q.st_w),
        .flags(nz_out)
    );

    assign ret_pc = s_q.pc_w + PCW'(2);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        acc      = ACC_NONE;
        wdata    = '0;
        last     = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.step  = '0;
                s_d.op    = seq_op_e'(op);
                s_d.pc_w  = pc_in;
                s_d.st_w  = status_in;
                s_d.reg_w = reg_in;
                s_d.tgt_w = target_in;
            end
        end else begin
            s_d.step = s_q.step + 1'b1;
            case (s_q.op)
                OP_PUSH: begin
                    acc   = ACC_PUSH;
                    wdata = s_q.reg_w;
                    last  = 1'b1;
                end
                OP_PULL: begin
                    acc        = ACC_PULL;
                    s_d.data_r = mem_rdata;
                    s_d.st_r   = nz_out;
                    last       = 1'b1;
                end
                OP_PULL_ST: begin
                    acc      = ACC_PULL;
                    s_d.st_r = mem_rdata;
                    last     = 1'b1;
                end
                OP_CALL: begin
                    acc   = ACC_PUSH;
                    wdata = (s_q.step == '0) ? s_q.pc_w[PCW-1:DW] : s_q.pc_w[DW-1:0];
                    if (s_q.step == STW'(1)) begin
                        s_d.pc_r = s_q.tgt_w;
                        last     = 1'b1;
                    end
                end
                OP_RET: begin
                    acc = ACC_PULL;
                    if (s_q.step == '0) begin
                        s_d.tmp = mem_rdata;
                    end else begin
                        s_d.pc_r = {mem_rdata, s_q.tmp} + PCW'(1);
                        last     = 1'b1;
                    end
                end
                OP_SWI: begin
                    case (s_q.step)
                        STW'(0): begin acc = ACC_PUSH; wdata = ret_pc[PCW-1:DW]; end
                        STW'(1): begin acc = ACC_PUSH; wdata = ret_pc[DW-1:0]; end
                        STW'(2): begin acc = ACC_PUSH; wdata = s_q.st_w; end
                        STW'(3): begin acc = ACC_VEC_LO; s_d.tmp = mem_rdata; end
                        default: begin
                            acc      = ACC_VEC_HI;
                            s_d.pc_r = {mem_rdata, s_q.tmp};
                            s_d.st_r = s_q.st_w | (DW'(1) << IBIT);
                            last     = 1'b1;
                        end
                    endcase
                end
                OP_RTI: begin
                    acc = ACC_PULL;
                    case (s_q.step)
                        STW'(0): s_d.st_w = mem_rdata;
                        STW'(1): s_d.tmp  = mem_rdata;
                        default: begin
                            s_d.pc_r = {mem_rdata, s_q.tmp};
                            s_d.st_r = s_q.st_w;
                            last     = 1'b1;
                        end
                    endcase
                end
                OP_FROM_SP: begin
                    s_d.data_r = DW'(s_q.sp);
                    s_d.st_r   = nz_out;
                    last       = 1'b1;
                end
                default: begin
                    s_d.st_r = s_q.st_w;
                    last     = 1'b1;
                end
            endcase
            s_d.sp = sp_nxt;
            if (s_q.op == OP_TO_SP) begin
                s_d.sp = SW'(s_q.reg_w);
            end
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.sp <= SP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_wdata  = wdata;
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign sp_out     = s_q.sp;
    assign pc_out     = s_q.pc_r;
    assign status_out = s_q.st_r;
    assign data_out   = s_q.data_r;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R1
    write_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:SW] == PAGE[AW-1:SW]));

    // R1
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == SW'($past(sp_out) - 1'b1)));

    // R10
    idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sp_out));

endmodule

// File: tb/test_stack_seq.sv
module test_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  reg_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  st_i = '0;
    logic [15:0] tgt_i = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [7:0]  sp_out, status_out, data_out;
    logic [15:0] pc_out;
    logic [7:0]  stk [256];
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    stack_seq i_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .reg_in(reg_i),
        .pc_in(pc_i), .status_in(st_i), .target_in(tgt_i),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
        .pc_out(pc_out), .status_out(status_out), .data_out(data_out)
    );

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr == 16'hFFFE) ? 8'hDE :
                       (mem_addr == 16'hFFFF) ? 8'hC0 : 8'h00;

    always @(posedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [7:0] r, input logic [15:0] pc,
                          input logic [7:0] st, input logic [15:0] tg, input logic poke,
                          output int cyc);
        @(negedge clk);
        start = 1'b1; op_i = o; reg_i = r; pc_i = pc; st_i = st; tgt_i = tg;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            start = 1'b1; op_i = 4'd0; reg_i = 8'h99;
        end
        cyc = 0;
        while (done !== 1'b1 && cyc < 40) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(busy === 1'b0, "R10 busy low at done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk(sp_out == 8'hFF, "R11 sp", 32'(sp_out), 32'hFF);
        chk(busy == 1'b0 && done == 1'b0, "R11 busy/done", {busy, done}, 32'd0);
        chk(pc_out == 16'h0 && status_out == 8'h0 && data_out == 8'h0, "R11 outputs",
            {pc_out, status_out, data_out}, 32'd0);
    endtask

    task automatic t_push_pull();
        int c;
        run_op(4'd0, 8'hA5, 16'h0, 8'h0, 16'h0, 1'b0, c);
        chk(c == 1, "R10 push cycles", c, 1);
        chk(stk[8'hFF] == 8'hA5, "R1 push data", 32'(stk[8'hFF]), 32'hA5);
        chk(sp_out == 8'hFE, "R1 push sp", 32'(sp_out), 32'hFE);
        run_op(4'd1, 8'h0, 16'h0, 8'hC3, 16'h0, 1'b0, c);
        chk(c == 1, "R10 pull cycles", c, 1);
        chk(data_out == 8'hA5, "R2 pull data", 32'(data_out), 32'hA5);
        chk(status_out == 8'hC1, "R2 pull flags nonzero", 32'(status_out), 32'hC1);
        chk(sp_out == 8'hFF, "R2 pull sp", 32'(sp_out), 32'hFF);
        run_op(4'd0, 8'h00, 16'h0, 8'h0, 16'h0, 1'b0, c);
        run_op(4'd1, 8'h0, 16'h0, 8'h81, 16'h0, 1'b0, c);
        chk(status_out == 8'h03, "R2 pull flags zero", 32'(status_out), 32'h03);
        run_op(4'd0, 8'h5A, 16'h0, 8'h0, 16'h0, 1'b0, c);
        run_op(4'd2, 8'h0, 16'h0, 8'hFF, 16'h0, 1'b0, c);
        chk(status_out == 8'h5A, "R3 status pull", 32'(status_out), 32'h5A);
        chk(sp_out == 8'hFF, "R3 sp", 32'(sp_out), 32'hFF);
    endtask

    task automatic t_call_ret();
        int c;
        run_op(4'd3, 8'h0, 16'h1234, 8'h0, 16'hBEEF, 1'b0, c);
        chk(c == 2, "R10 call cycles", c, 2);
        chk({stk[8'hFF], stk[8'hFE]} == 16'h1234, "R4 pushed order",
            {stk[8'hFF], stk[8'hFE]}, 32'h1234);
        chk(sp_out == 8'hFD, "R4 sp", 32'(sp_out), 32'hFD);
        chk(pc_out == 16'hBEEF, "R4 pc", 32'(pc_out), 32'hBEEF);
        run_op(4'd4, 8'h0, 16'h0, 8'h0, 16'h0, 1'b0, c);
        chk(c == 2, "R10 ret cycles", c, 2);
        chk(pc_out == 16'h1235, "R5 pc plus one", 32'(pc_out), 32'h1235);
        chk(sp_out == 8'hFF, "R5 sp", 32'(sp_out), 32'hFF);
    endtask

    task automatic t_swi_rti();
        int c;
        stk[8'hFC] = 8'h77;
        run_op(4'd5, 8'h0, 16'h20FE, 8'h41, 16'h0, 1'b1, c);
        chk(c == 5, "R10 swi cycles", c, 5);
        chk({stk[8'hFF], stk[8'hFE], stk[8'hFD]} == 24'h210041, "R6 pushed bytes",
            {stk[8'hFF], stk[8'hFE], stk[8'hFD]}, 32'h210041);
        chk(pc_out == 16'hC0DE, "R6 vector", 32'(pc_out), 32'hC0DE);
        chk(status_out == 8'h45, "R6 disable bit", 32'(status_out), 32'h45);
        chk(sp_out == 8'hFC, "R10 start ignored sp", 32'(sp_out), 32'hFC);
        chk(stk[8'hFC] == 8'h77, "R10 start ignored mem", 32'(stk[8'hFC]), 32'h77);
        run_op(4'd6, 8'h0, 16'h0, 8'hFF, 16'h0, 1'b0, c);
        chk(c == 3, "R10 rti cycles", c, 3);
        chk(status_out == 8'h41, "R7 status", 32'(status_out), 32'h41);
        chk(pc_out == 16'h2100, "R7 pc no increment", 32'(pc_out), 32'h2100);
        chk(sp_out == 8'hFF, "R7 sp", 32'(sp_out), 32'hFF);
    endtask

    task automatic t_sp_moves();
        int c;
        stk[8'h00] = 8'h11;
        run_op(4'd7, 8'h00, 16'h0, 8'h81, 16'h0, 1'b0, c);
        chk(c == 1, "R10 to-sp cycles", c, 1);
        chk(sp_out == 8'h00, "R8 sp loaded", 32'(sp_out), 32'h00);
        chk(status_out == 8'h81, "R8 flags unchanged", 32'(status_out), 32'h81);
        chk(stk[8'h00] == 8'h11, "R8 no write", 32'(stk[8'h00]), 32'h11);
        run_op(4'd8, 8'h0, 16'h0, 8'h80, 16'h0, 1'b0, c);
        chk(data_out == 8'h00 && status_out == 8'h02, "R9 copy zero",
            {data_out, status_out}, 32'h0002);
        run_op(4'd0, 8'h3C, 16'h0, 8'h0, 16'h0, 1'b0, c);
        chk(stk[8'h00] == 8'h3C && sp_out == 8'hFF, "R1 wrap down",
            {stk[8'h00], sp_out}, 32'h3CFF);
        run_op(4'd1, 8'h0, 16'h0, 8'h00, 16'h0, 1'b0, c);
        chk(data_out == 8'h3C && sp_out == 8'h00, "R2 wrap up",
            {data_out, sp_out}, 32'h3C00);
        run_op(4'd7, 8'h90, 16'h0, 8'h0, 16'h0, 1'b0, c);
        run_op(4'd8, 8'h0, 16'h0, 8'h00, 16'h0, 1'b0, c);
        chk(data_out == 8'h90 && status_out == 8'h80, "R9 copy negative",
            {data_out, status_out}, 32'h9080);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pull();
        t_call_ret();
        t_swi_rti();
        t_sp_moves();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule